// File: doc/BRIEF.md
# Memory Controller Performance Counter Unit

This unit sits beside a DRAM controller and counts what the controller does. It holds four counters of `CNT_W` bits. Counter 0 is a free-running clock-cycle counter that also acts as the master: its overflow freezes the whole unit and raises the single interrupt line. Counters 1 to 3 each choose one controller event by an 8-bit code and count the clocks in which that event's strobe is high. They run only while the cycle counter is enabled and has not overflowed. A general counter that overflows wraps to zero and keeps counting.

Software reaches the unit through a flat 32-bit register port with a write strobe, a byte address and a combinational read path. Each counter has one control word and one count word. A measurement is started by writing enable and clear together with an event code. To restart a counter that is already running, software first writes zero to its control word.

Top module: `mc_perf_counters`

## Requirements
- R1: After reset every control word and every count word reads 0 and `irq` is low.
- R2: A control write with enable (bit 2) set to a disabled counter enables it, loads the event code and clears its overflow flag. If clear (bit 1) is also set, the count becomes 0; otherwise counting resumes from the held value. A running cycle counter adds exactly one per clock.
- R3: A running general counter adds one in each clock where the strobe at index equal to its code is high, and at most one per clock. Strobes for other codes have no effect. Code 0x00, and codes at or above the strobe vector width, count nothing.
- R4: Counter 0 ignores the event code field of a write, and its control word reads 0 in bits 31:24.
- R5: A control write with enable set to a counter that is already enabled is ignored. The code, the count and the enable state are unchanged, and counting continues.
- R6: A control write with enable clear stops that counter and keeps its count, its event code and its overflow flag.
- R7: General counters hold their value while the cycle counter is disabled.
- R8: A general counter at all ones that counts again wraps to 0, sets its overflow flag (bit 0), keeps counting and leaves `irq` low and the cycle counter running.
- R9: When the cycle counter wraps from all ones, it reads 0, its overflow flag sets and `irq` goes high as a level. All four counters then hold until counter 0 is disabled and then re-enabled, which lowers `irq`. General counters still count strobes in the wrap cycle itself.
- R10: Counter n's control word is at byte offset 4·n and its count word at 0x20 + 4·n. The control word fields are: bit 0 overflow flag, bit 1 clear (always reads 0), bit 2 enable, bits 31:24 event code. Count words read zero-extended. Every other offset reads 0, and writes to those offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_strobe | input | EVT_N | Single-cycle event strobes, indexed by event code |
| irq | output | 1 | High while the cycle counter's overflow flag is set |

## Verification
The case that needs care is a general counter wrapping in the same clock as the cycle counter. A general counter is cleared and given a strobe held high. The cycle counter is then started with clear, so both counters reach all ones together and wrap on the same edge. The bench reads both counters one cycle before the wrap and again on the wrap cycle. It expects both counts to be 0 with both overflow flags set and `irq` high. Ten further cycles with the strobe still high must leave both counts at 0.

// File: rtl/mc_perf_counters.sv
`timescale 1ns/1ps
module mc_perf_counters #(
  parameter int CNT_W  = 32,
  parameter int EVT_N  = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [EVT_N-1:0]  evt_strobe,
  output logic              irq
);
  localparam int NCNT      = 4;
  localparam int SEL_W     = 8;
  localparam int EVT_SPACE = 1 << SEL_W;
  localparam int CNT_BASE  = 32;

  logic [CNT_W-1:0]     cnt_q [NCNT];
  logic [SEL_W-1:0]     sel_q [NCNT];
  logic [NCNT-1:0]      en_q, ovf_q;
  logic [EVT_SPACE-1:0] evt_pad;
  logic                 run;
  logic                 unused_wbits;

  assign evt_pad      = EVT_SPACE'(evt_strobe);
  assign run          = en_q[0] & ~ovf_q[0];
  assign irq          = ovf_q[0];
  assign unused_wbits = ^{bus_wdata[23:3], bus_wdata[0]};

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    logic wr_c, take, hit;
    assign wr_c = bus_wr && (bus_addr == ADDR_W'(4 * g));
    assign take = wr_c && (!bus_wdata[2] || !en_q[g]);
    if (g == 0) begin : g_cyc
      assign hit = run;
    end else begin : g_gen
      assign hit = en_q[g] && run && (sel_q[g] != '0) && evt_pad[sel_q[g]];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt_q[g] <= '0;
        sel_q[g] <= '0;
        en_q[g]  <= 1'b0;
        ovf_q[g] <= 1'b0;
      end else if (take) begin
        if (bus_wdata[2]) begin
          en_q[g]  <= 1'b1;
          ovf_q[g] <= 1'b0;
          sel_q[g] <= (g == 0) ? '0 : bus_wdata[31:24];
          if (bus_wdata[1]) cnt_q[g] <= '0;
        end else begin
          en_q[g] <= 1'b0;
        end
      end else if (hit) begin
        cnt_q[g] <= cnt_q[g] + CNT_W'(1);
        if (&cnt_q[g]) ovf_q[g] <= 1'b1;
      end
    end

    // R9
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[0] && !bus_wr) |=> $stable(cnt_q[g]));

    // R3
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> (CNT_W'(cnt_q[g] - $past(cnt_q[g])) <= CNT_W'(1)));

    // R5
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_c && bus_wdata[2] && en_q[g]) |=> ($stable(sel_q[g]) && en_q[g]));

    if (g > 0) begin : g_hold
      // R7
      idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[0] && !bus_wr) |=> $stable(cnt_q[g]));
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NCNT; i++) begin
      if (bus_addr == ADDR_W'(4 * i))
        bus_rdata = {sel_q[i], 21'b0, en_q[i], 1'b0, ovf_q[i]};
      if (bus_addr == ADDR_W'(CNT_BASE + 4 * i))
        bus_rdata = 32'(cnt_q[i]);
    end
  end

  // R2
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !bus_wr) |=> (cnt_q[0] == $past(cnt_q[0]) + CNT_W'(1)));

  // R9
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(&cnt_q[0]));
endmodule

// File: tb/mc_perf_counters_tb_top.sv
`timescale 1ns/1ps
module mc_perf_counters_tb_top;
  localparam int CW = 8;
  localparam int EN = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [EN-1:0] evt = '0;
  logic        irq;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] d;

  mc_perf_counters #(.CNT_W(CW), .EVT_N(EN), .ADDR_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_strobe(evt), .irq(irq));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.2;
    v = bus_rdata;
  endtask

  task automatic pulse(input logic [EN-1:0] m, input int n);
    evt = m;
    repeat (n) @(negedge clk);
    evt = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(8'(4 * i), d); chk("R1 ctrl", d, 0);
      rd(8'(32 + 4 * i), d); chk("R1 count", d, 0);
    end
    chk("R1 irq", {31'b0, irq}, 0);
    @(negedge clk);

    // R2 cycle counter start and step
    wr(8'h00, 32'h6);
    rd(8'h00, d); chk("R10 ctrl0 clear bit reads 0", d, 32'h4);
    idle(10);
    rd(8'h20, d); chk("R2 cycle count", d, 10);
    // R6 disable keeps count
    wr(8'h00, 32'h0);
    rd(8'h20, d); chk("R6 cycle count held", d, 10);
    rd(8'h00, d); chk("R6 ctrl0 disabled", d, 32'h0);
    // R4 code ignored on counter 0, R2 resume without clear
    wr(8'h00, 32'h0A00_0004);
    rd(8'h00, d); chk("R4 ctrl0 code field", d, 32'h4);
    idle(3);
    rd(8'h20, d); chk("R2 resume from held", d, 13);

    // R3 selected event only
    wr(8'h04, 32'h0500_0006);
    pulse((64'b1 << 6) | 64'b1, 4);
    pulse(64'b1 << 5, 7);
    rd(8'h24, d); chk("R3 counter1 code 5", d, 7);
    // R5 re-enable while enabled ignored
    wr(8'h04, 32'h0700_0006);
    rd(8'h04, d); chk("R5 ctrl1 unchanged", d, 32'h0500_0004);
    pulse(64'b1 << 5, 2);
    rd(8'h24, d); chk("R5 counting continues", d, 9);
    // R7 hold with cycle counter off
    wr(8'h00, 32'h0);
    pulse(64'b1 << 5, 4);
    rd(8'h24, d); chk("R7 general held", d, 9);
    // R6 general disable keeps fields
    wr(8'h04, 32'h0);
    rd(8'h04, d); chk("R6 ctrl1 kept code", d, 32'h0500_0000);
    rd(8'h24, d); chk("R6 count1 kept", d, 9);

    // R8 general wrap
    wr(8'h00, 32'h6);
    wr(8'h08, 32'h0700_0006);
    pulse(64'b1 << 7, 200);
    wr(8'h00, 32'h0);
    wr(8'h00, 32'h6);
    pulse(64'b1 << 7, 59);
    rd(8'h28, d); chk("R8 wrapped count", d, 3);
    rd(8'h08, d); chk("R8 flag set", d, 32'h0700_0005);
    rd(8'h20, d); chk("R8 cycle counter running", d, 59);
    chk("R8 no irq", {31'b0, irq}, 0);
    wr(8'h08, 32'h0);
    rd(8'h08, d); chk("R6 flag kept on disable", d, 32'h0700_0001);
    wr(8'h08, 32'h0700_0004);
    rd(8'h08, d); chk("R2 flag cleared on enable", d, 32'h0700_0004);
    rd(8'h28, d); chk("R2 count kept without clear", d, 3);

    // R3 codes that count nothing
    wr(8'h0C, 32'hF000_0006);
    pulse('1, 5);
    rd(8'h2C, d); chk("R3 code above width", d, 0);
    wr(8'h0C, 32'h0);
    wr(8'h0C, 32'h6);
    pulse('1, 5);
    rd(8'h2C, d); chk("R3 code zero", d, 0);

    // R3 sweep over all codes
    for (int c = 1; c < EN; c++) begin
      logic [EN-1:0] m;
      int k;
      m = 64'b1 << c;
      k = (c % 5) + 1;
      wr(8'h00, 32'h0);
      wr(8'h00, 32'h6);
      wr(8'h04, 32'h0);
      wr(8'h04, {8'(c), 24'h6});
      pulse(~m, 3);
      pulse(m, k);
      rd(8'h24, d); chk($sformatf("R3 sweep code %0d", c), d, 32'(k));
    end

    // R9 cycle overflow, coinciding with a general wrap
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);
    wr(8'h04, 32'h0500_0006);
    evt = 64'b1 << 5;
    wr(8'h00, 32'h6);
    idle(255);
    rd(8'h20, d); chk("R9 cycle before wrap", d, 255);
    rd(8'h24, d); chk("R9 general before wrap", d, 255);
    chk("R9 irq before wrap", {31'b0, irq}, 0);
    idle(1);
    chk("R9 irq raised", {31'b0, irq}, 1);
    rd(8'h20, d); chk("R9 cycle wrapped", d, 0);
    rd(8'h00, d); chk("R9 ctrl0 flag", d, 32'h5);
    rd(8'h24, d); chk("R9 general wrapped same cycle", d, 0);
    rd(8'h04, d); chk("R8 ctrl1 flag", d, 32'h0500_0005);
    idle(10);
    rd(8'h20, d); chk("R9 cycle frozen", d, 0);
    rd(8'h24, d); chk("R9 general frozen", d, 0);
    chk("R9 irq level", {31'b0, irq}, 1);
    evt = '0;
    wr(8'h00, 32'h0);
    chk("R9 irq kept after disable", {31'b0, irq}, 1);
    rd(8'h00, d); chk("R9 ctrl0 after disable", d, 32'h1);
    wr(8'h00, 32'h6);
    chk("R9 irq cleared by re-enable", {31'b0, irq}, 0);
    rd(8'h00, d); chk("R9 ctrl0 re-enabled", d, 32'h4);

    // R10 unmapped offsets
    rd(8'h10, d); chk("R10 read 0x10", d, 0);
    rd(8'h30, d); chk("R10 read 0x30", d, 0);
    rd(8'h22, d); chk("R10 read 0x22", d, 0);
    rd(8'hFF, d); chk("R10 read 0xFF", d, 0);
    @(negedge clk);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R10 write 0x10 ignored", d, 0);
    rd(8'h00, d); chk("R10 ctrl0 untouched", d, 32'h4);
    rd(8'h04, d); chk("R10 ctrl1 untouched", d, 32'h0500_0005);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule